// File: doc/BRIEF.md
# Memory-Mapped Decrementer Timer

This block is a down-counting timer that sits on a processor's internal bus. Software writes a period to one fixed word address. That write loads both a reload register and the live counter. A read at the same address returns the current count. Two single-bit control flags are written through a separate bit-addressed port. One flag chooses the tick source and the other starts or stops counting.

In timer mode the counter steps once every `PRESCALE` clock cycles. In event mode it steps once on each falling edge of an external input, after that input has passed through a two-flop synchroniser. When a period expires, the counter takes the reload value again and the block raises a one-clock interrupt request. The interrupt is meant for the processor's level-3 decrementer interrupt. Prioritisation of that request happens outside this block.

Top module: `dec_timer`

## Requirements
- R1: A bus write with `bus_addr` equal to `REG_ADDR` (default 0xFFFA) loads `bus_wdata` into both the reload register and the counter at that clock edge. `bus_rdata` shows the counter whenever `bus_addr` equals `REG_ADDR` and shows 0 for any other address. A write to any other address changes nothing.
- R2: With flag 0 = 1 (timer mode) and counting enabled, the counter decrements once every `PRESCALE` clocks. The first decrement comes `PRESCALE` clocks after the edge that enables counting.
- R3: After N is loaded, the N-th tick reloads the counter with N and sets `irq` high for exactly one clock. In timer mode the first pulse therefore appears N*`PRESCALE` clocks after counting starts, and each later pulse follows N*`PRESCALE` clocks after the previous one.
- R4: Flag 1 = 1 enables counting. Writing 0 to flag 1 freezes the counter at its present value.
- R5: With flag 0 = 0 (event mode), each falling edge of `evt_in` decrements the counter exactly once, three clocks after the edge is presented. Rising edges have no effect.
- R6: A reload value of 0 never produces an `irq` pulse, and the counter stays at 0.
- R7: Reset clears both flags, the counter and the reload register, and holds `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor output clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Word address on the bus |
| bus_we | input | 1 | Bus write strobe |
| bus_wdata | input | W | Bus write data |
| bus_rdata | output | W | Current count when the address matches, otherwise 0 |
| flag_we | input | 1 | Flag write strobe |
| flag_sel | input | 1 | Flag index: 0 selects the tick source, 1 enables counting |
| flag_val | input | 1 | Value written to the selected flag |
| evt_in | input | 1 | Asynchronous event input |
| irq | output | 1 | One-clock expiry interrupt request |

## Verification
The bench uses the default parameters: a 16-bit counter, a 16-bit address with the register at 0xFFFA, and a prescale of 4. Small periods such as 2 and 3 bring several expiries and reloads into a few dozen cycles. This makes exact pulse timing and pulse width measurable in both timer and event mode. A prescale of 4 also leaves room to observe that the counter does not move between ticks.

// File: rtl/dec_timer.sv
module dec_timer #(
  parameter int W = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] REG_ADDR = 16'hFFFA,
  parameter int PRESCALE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic          flag_we,
  input  logic          flag_sel,
  input  logic          flag_val,
  input  logic          evt_in,
  output logic          irq
);
  localparam int PW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [W-1:0]  count, reload;
  logic [PW-1:0] presc;
  logic          tmode, run;
  logic          s1, s2, s3;

  wire hit    = bus_addr == REG_ADDR;
  wire wr_hit = bus_we && hit;
  wire fall   = s3 && !s2;
  wire tick   = run && (tmode ? (presc == PLAST) : fall);
  wire expire = count <= W'(1);

  assign bus_rdata = hit ? count : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tmode <= 1'b0;
      run   <= 1'b0;
    end else if (flag_we) begin
      if (flag_sel) run <= flag_val;
      else          tmode <= flag_val;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {evt_in, s1, s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      presc <= '0;
    else if (!run || !tmode || wr_hit || presc == PLAST) presc <= '0;
    else                             presc <= presc + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count  <= '0;
      reload <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (wr_hit) begin
        count  <= bus_wdata;
        reload <= bus_wdata;
      end else if (tick) begin
        if (expire) begin
          count <= reload;
          irq   <= reload != '0;
        end else begin
          count <= count - 1'b1;
        end
      end
    end

  a_r1_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (count == $past(bus_wdata)) && (reload == $past(bus_wdata)));

  a_r2_no_step_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tmode && !wr_hit && presc != PLAST) |=> $stable(count));

  a_r3_reloaded_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count == reload) && (reload != '0));

  a_r4_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_hit) |=> $stable(count));

  a_r6_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (reload == '0 && !wr_hit) |=> !irq);
endmodule

// File: tb/tb_dec_timer.sv
module tb_dec_timer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = 16'h0000, bus_wdata = 16'h0000;
  logic        bus_we = 1'b0, flag_we = 1'b0, flag_sel = 1'b0, flag_val = 1'b0;
  logic        evt_in = 1'b1;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0, fails = 0, irq_cnt = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  dec_timer dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flag_we(flag_we), .flag_sel(flag_sel),
    .flag_val(flag_val), .evt_in(evt_in), .irq(irq));

  always @(posedge clk) if (rst_n && irq) irq_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic rd(output logic [15:0] v);
    bus_addr = 16'hFFFA; #1; v = bus_rdata;
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] v);
    @(negedge clk); bus_addr = a; bus_wdata = v; bus_we = 1'b1;
    @(posedge clk); #1 bus_we = 1'b0; bus_addr = 16'hFFFA;
  endtask

  task automatic flag(input logic s, input logic v);
    @(negedge clk); flag_sel = s; flag_val = v; flag_we = 1'b1;
    @(posedge clk); #1 flag_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(v); chk("R7 count after reset", v, 0);
    chk("R7 irq after reset", irq, 0);
  endtask

  task automatic t_bus;
    logic [15:0] v;
    wr(16'hFFFA, 16'd9); rd(v); chk("R1 write loads count", v, 9);
    wr(16'hFFF8, 16'd7); rd(v); chk("R1 other address write ignored", v, 9);
    bus_addr = 16'hFFF8; #1 chk("R1 other address reads 0", bus_rdata, 0);
  endtask

  task automatic t_timer;
    logic [15:0] v;
    int first = 0, second = 0;
    wr(16'hFFFA, 16'd3);
    flag(1'b0, 1'b1);
    flag(1'b1, 1'b1);
    for (int k = 1; k <= 30; k++) begin
      @(posedge clk); #1;
      if (k == 3) begin rd(v); chk("R2 no step before 4 clocks", v, 3); end
      if (k == 4) begin rd(v); chk("R2 step after 4 clocks", v, 2); end
      if (irq && first == 0) begin
        first = k; rd(v); chk("R3 reloaded at expiry", v, 3);
      end else if (irq && second == 0) second = k;
      if (k == 13) chk("R3 irq one clock wide", irq, 0);
    end
    chk("R3 first irq cycle", first, 12);
    chk("R3 second irq cycle", second, 24);
  endtask

  task automatic t_stop;
    logic [15:0] a, b;
    flag(1'b1, 1'b0);
    rd(a);
    repeat (20) @(posedge clk); #1;
    rd(b); chk("R4 stopped count held", b, a);
  endtask

  task automatic t_event;
    logic [15:0] v;
    int base;
    flag(1'b0, 1'b0);
    wr(16'hFFFA, 16'd5);
    flag(1'b1, 1'b1);
    repeat (8) @(posedge clk); #1;
    rd(v); chk("R5 no tick without edges", v, 5);
    for (int p = 0; p < 2; p++) begin
      @(negedge clk) evt_in = 1'b0;
      repeat (2) @(posedge clk); #1;
      rd(v); chk("R5 not yet after 2 clocks", v, 5 - p);
      @(posedge clk); #1;
      rd(v); chk("R5 falling edge decrements", v, 4 - p);
      @(negedge clk) evt_in = 1'b1;
      repeat (5) @(posedge clk); #1;
      rd(v); chk("R5 rising edge ignored", v, 4 - p);
    end
    wr(16'hFFFA, 16'd2);
    base = irq_cnt;
    for (int p = 0; p < 2; p++) begin
      @(negedge clk) evt_in = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk) evt_in = 1'b1;
      repeat (4) @(posedge clk);
    end
    #1 rd(v); chk("R3 event expiry reload", v, 2);
    chk("R3 event expiry single irq", irq_cnt - base, 1);
  endtask

  task automatic t_zero;
    logic [15:0] v;
    int base;
    flag(1'b0, 1'b1);
    wr(16'hFFFA, 16'd0);
    base = irq_cnt;
    repeat (40) @(posedge clk); #1;
    chk("R6 zero reload no irq", irq_cnt - base, 0);
    rd(v); chk("R6 zero count stays", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1'b1;
    t_reset(); t_bus(); t_timer(); t_stop(); t_event(); t_zero();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule